// File: doc/BRIEF.md
# Free-Running Idle Interval Timer

This block is a down counter that keeps running for as long as the chip is out of reset. It moves one step for each instruction cycle, which a one-cycle strobe marks. Software cannot see the count and cannot change it. The block's main product is a steady real-time tick. Each time one chosen interior bit of the count changes value, in either direction, the block records an event in a sticky pending flag. An enable flag that software controls then passes that event through to the interrupt line.

The count also drives a zero-detect output. Surrounding logic uses it for timed work such as a watchdog, a wake-up from idle, a delay after halt, or the width of the internal power-on reset. That logic is not part of this block. Software sees a small command port with three inputs. One writes the enable flag, with its data bit. One clears the pending flag. The pending and enable flags are visible as outputs.

Top module: `idle_tick_timer`

## Requirements
- R1: A clock edge with `rst` high loads the count with zero and clears the pending and enable flags. Just after reset, `irq` is 0, `pend_o` is 0, `en_o` is 0 and `tc_o` is 1.
- R2: Each clock edge with `cycle_stb` high lowers the 16-bit count by one. Decrementing from zero gives 0xFFFF. An edge with `cycle_stb` low leaves the count unchanged. So after 65536 advances the count is back at its starting value.
- R3: The tap is bit index 12 of the count. `pend_o` rises one clock after any edge that changes the tap bit. With the strobe held high this happens on the first advance out of zero (0 to 0xFFFF) and then once every 4096 advances.
- R4: Once set, `pend_o` stays at 1 until a clock edge with `sw_pend_clr` high.
- R5: If a tap change and `sw_pend_clr` arrive at the same edge, the tap change wins and `pend_o` is 1 afterwards.
- R6: An edge with `sw_en_we` high copies `sw_en_d` into `en_o`. An edge with `sw_en_we` low keeps `en_o`.
- R7: `irq` is 1 exactly when `pend_o` and `en_o` are both 1.
- R8: `tc_o` is 1 exactly while the count is zero.
- R9: None of the command inputs changes the count. The timing of `tc_o` and of the pending events depends only on `cycle_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cycle_stb | input | 1 | Instruction-cycle strobe; the count advances on edges where it is high |
| sw_en_we | input | 1 | Write strobe for the interrupt enable flag |
| sw_en_d | input | 1 | Value written into the enable flag |
| sw_pend_clr | input | 1 | Clear request for the pending flag |
| irq | output | 1 | Interrupt request, pending gated by enable |
| pend_o | output | 1 | Pending tick flag |
| en_o | output | 1 | Interrupt enable flag |
| tc_o | output | 1 | High while the count is zero |

## Verification
The bench follows three corner cases.

The first is the wrap from zero to all ones. It flips the tap bit at once, so a design that counted up or saturated at zero would miss the first tick. It would also bring `tc_o` back at the wrong interval.

The second is a clear request that lands on the same edge as a tap change. A design that gave the clear priority would drop that tick.

The third is a long stretch with the strobe low while the command inputs keep changing. A design that let a command write reach the count, or that detected only one edge direction of the tap, would shift or halve the tick rate. The per-cycle model comparison would show this.

// File: rtl/idle_tick_pkg.sv
package idle_tick_pkg;

    localparam int unsigned DEF_CNT_W   = 16;
    localparam int unsigned DEF_TAP_BIT = 12;

    typedef struct packed {
        logic en_we;
        logic en_d;
        logic pend_clr;
    } tick_cmd_t;

    typedef struct packed {
        logic pend;
        logic en;
    } tick_flags_t;

    // A tap change outranks a clear request arriving on the same edge.
    function automatic logic next_pend(input logic toggle, input logic clr,
                                       input logic cur);
        logic r;
        if (toggle)
            r = 1'b1;
        else if (clr)
            r = 1'b0;
        else
            r = cur;
        return r;
    endfunction

    function automatic logic next_en(input logic we, input logic d,
                                     input logic cur);
        return we ? d : cur;
    endfunction

endpackage

// File: rtl/idle_down_counter.sv
module idle_down_counter #(
    parameter int unsigned CNT_W   = idle_tick_pkg::DEF_CNT_W,
    parameter int unsigned TAP_BIT = idle_tick_pkg::DEF_TAP_BIT
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic tap,
    output logic zero
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= cnt_q - ONE;
    end

    assign tap  = cnt_q[TAP_BIT];
    assign zero = (cnt_q == '0);
endmodule

// File: rtl/idle_tap_edge.sv
module idle_tap_edge (
    input  logic clk,
    input  logic rst,
    input  logic tap,
    output logic toggle
);
    logic tap_q;

    always_ff @(posedge clk) begin
        if (rst)
            tap_q <= 1'b0;
        else
            tap_q <= tap;
    end

    assign toggle = tap ^ tap_q;
endmodule

// File: rtl/idle_irq_flags.sv
module idle_irq_flags
    import idle_tick_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        toggle,
    input  tick_cmd_t   cmd,
    output tick_flags_t flags
);
    tick_flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q.pend <= next_pend(toggle, cmd.pend_clr, flags_q.pend);
            flags_q.en   <= next_en(cmd.en_we, cmd.en_d, flags_q.en);
        end
    end

    assign flags = flags_q;
endmodule

// File: rtl/idle_tick_timer.sv
module idle_tick_timer
    import idle_tick_pkg::*;
#(
    parameter int unsigned CNT_W   = DEF_CNT_W,
    parameter int unsigned TAP_BIT = DEF_TAP_BIT
) (
    input  logic clk,
    input  logic rst,
    input  logic cycle_stb,
    input  logic sw_en_we,
    input  logic sw_en_d,
    input  logic sw_pend_clr,
    output logic irq,
    output logic pend_o,
    output logic en_o,
    output logic tc_o
);
    localparam int unsigned TAP_SEL = (TAP_BIT < CNT_W) ? TAP_BIT : CNT_W - 1;

    logic        tap_bit;
    logic        tap_toggle;
    tick_cmd_t   cmd;
    tick_flags_t flags;

    assign cmd.en_we    = sw_en_we;
    assign cmd.en_d     = sw_en_d;
    assign cmd.pend_clr = sw_pend_clr;

    idle_down_counter #(.CNT_W(CNT_W), .TAP_BIT(TAP_SEL)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .adv  (cycle_stb),
        .tap  (tap_bit),
        .zero (tc_o)
    );

    idle_tap_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .tap    (tap_bit),
        .toggle (tap_toggle)
    );

    idle_irq_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .toggle (tap_toggle),
        .cmd    (cmd),
        .flags  (flags)
    );

    assign pend_o = flags.pend;
    assign en_o   = flags.en;
    assign irq    = flags.pend & flags.en;
endmodule

// File: rtl/idle_tick_timer_chk.sv
module idle_tick_timer_chk (
    input logic clk,
    input logic rst,
    input logic cycle_stb,
    input logic sw_en_we,
    input logic sw_en_d,
    input logic sw_pend_clr,
    input logic irq,
    input logic pend_o,
    input logic en_o,
    input logic tc_o
);
    p_tc_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cycle_stb |=> $stable(tc_o));

    p_tc_leave_r8: assert property (@(posedge clk) disable iff (rst)
        tc_o && cycle_stb |=> !tc_o);

    p_pend_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_o) |-> $past(cycle_stb, 2));

    p_pend_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        pend_o && !sw_pend_clr |=> pend_o);

    p_en_write_r6: assert property (@(posedge clk) disable iff (rst)
        sw_en_we |=> en_o == $past(sw_en_d));

    p_en_keep_r6: assert property (@(posedge clk) disable iff (rst)
        !sw_en_we |=> $stable(en_o));

    p_irq_off_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(en_o) || $fell(pend_o) |-> !irq);

    p_irq_src_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> en_o && pend_o);
endmodule

bind idle_tick_timer idle_tick_timer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cycle_stb   (cycle_stb),
    .sw_en_we    (sw_en_we),
    .sw_en_d     (sw_en_d),
    .sw_pend_clr (sw_pend_clr),
    .irq         (irq),
    .pend_o      (pend_o),
    .en_o        (en_o),
    .tc_o        (tc_o)
);

// File: tb/idle_tick_timer_tb.sv
module idle_tick_timer_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cycle_stb = 1'b0;
    logic sw_en_we = 1'b0;
    logic sw_en_d = 1'b0;
    logic sw_pend_clr = 1'b0;
    logic irq, pend_o, en_o, tc_o;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;

    // behavioural reference
    int m_cnt = 0;
    int m_prev = 0;
    bit m_pend = 1'b0;
    bit m_en = 1'b0;
    int adv_cnt = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    idle_tick_timer u_dut (
        .clk(clk), .rst(rst), .cycle_stb(cycle_stb),
        .sw_en_we(sw_en_we), .sw_en_d(sw_en_d), .sw_pend_clr(sw_pend_clr),
        .irq(irq), .pend_o(pend_o), .en_o(en_o), .tc_o(tc_o)
    );

    function automatic int tap_of(input int c);
        return (c / 4096) % 2;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_cnt <= 0; m_prev <= 0; m_pend <= 1'b0; m_en <= 1'b0;
            adv_cnt <= 0;
        end else begin
            if (tap_of(m_cnt) != m_prev) m_pend <= 1'b1;
            else if (sw_pend_clr)        m_pend <= 1'b0;
            m_prev <= tap_of(m_cnt);
            if (cycle_stb) begin
                m_cnt <= (m_cnt + 65535) % 65536;
                adv_cnt <= adv_cnt + 1;
            end
            if (sw_en_we) m_en <= sw_en_d;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check("R3 pend_o", pend_o, m_pend);
            check("R6 en_o", en_o, m_en);
            check("R7 irq", irq, m_pend & m_en);
            check("R8 tc_o", tc_o, m_cnt == 0);
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic wr_en(input logic v);
        sw_en_we = 1'b1; sw_en_d = v;
        @(negedge clk);
        sw_en_we = 1'b0;
    endtask

    initial begin
        int last_rise;
        int gap;
        bit tc_seen;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;
        // R1: state right after reset
        check("R1 pend_o", pend_o, 1'b0);
        check("R1 en_o", en_o, 1'b0);
        check("R1 irq", irq, 1'b0);
        check("R1 tc_o", tc_o, 1'b1);

        // R6: enable writes
        wr_en(1'b1);
        check("R6 set", en_o, 1'b1);
        wr_en(1'b0);
        check("R6 clr", en_o, 1'b0);
        wr_en(1'b1);

        // R3: first advance out of zero toggles the tap
        cycle_stb = 1'b1;
        @(negedge clk);
        check("R2 left zero", tc_o, 1'b0);
        @(negedge clk);
        check("R3 first tick", pend_o, 1'b1);
        check("R7 irq on", irq, 1'b1);
        sw_pend_clr = 1'b1;
        @(negedge clk);
        sw_pend_clr = 1'b0;
        check("R4 cleared", pend_o, 1'b0);

        // R3: spacing of ticks under a continuous strobe
        last_rise = -1;
        for (int k = 0; k < 3; k++) begin
            while (pend_o !== 1'b1) @(negedge clk);
            if (last_rise >= 0) begin
                gap = cyc - last_rise;
                vectors++;
                if (gap != 4096) begin
                    fails++;
                    $display("FAIL R3 tick gap actual=%0d expected=4096", gap);
                end
            end
            last_rise = cyc;
            sw_pend_clr = 1'b1;
            @(negedge clk);
            sw_pend_clr = 1'b0;
        end

        // R4: pending holds without a clear
        while (pend_o !== 1'b1) @(negedge clk);
        repeat (3000) @(negedge clk);
        check("R4 sticky", pend_o, 1'b1);

        // R2: wrap brings zero back after 65536 advances
        tc_seen = 1'b0;
        while (adv_cnt < 65536) @(negedge clk);
        tc_seen = tc_o;
        check("R2 wrap to zero", tc_seen, 1'b1);

        // R5: clear collides with a tap change
        sw_pend_clr = 1'b1;
        repeat (10) @(negedge clk);
        while (tap_of(m_cnt) == m_prev) @(negedge clk);
        @(negedge clk);
        sw_pend_clr = 1'b0;
        check("R5 toggle beats clear", pend_o, 1'b1);

        // R9: strobe low, command inputs busy, count must not move
        sw_pend_clr = 1'b1;
        @(negedge clk);
        cycle_stb = 1'b0;
        @(negedge clk);
        sw_pend_clr = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 3000; i++) begin
            sw_en_we = $urandom_range(0, 1);
            sw_en_d = $urandom_range(0, 1);
            sw_pend_clr = $urandom_range(0, 1);
            @(negedge clk);
            if (pend_o === 1'b1) begin
                check("R9 no tick while stalled", pend_o, 1'b0);
                break;
            end
        end
        sw_pend_clr = 1'b0;
        sw_en_we = 1'b0;

        // mixed random strobe and commands, model compared every clock
        for (int i = 0; i < 30000; i++) begin
            cycle_stb = $urandom_range(0, 1);
            sw_en_we = ($urandom_range(0, 15) == 0);
            sw_en_d = $urandom_range(0, 1);
            sw_pend_clr = ($urandom_range(0, 31) == 0);
            @(negedge clk);
        end

        // clear held high with continuous strobe: one-cycle ticks
        cycle_stb = 1'b1;
        sw_pend_clr = 1'b1;
        sw_en_we = 1'b0;
        repeat (12000) @(negedge clk);
        sw_pend_clr = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule